// File: doc/BRIEF.md
# Clock-Pair Frequency Lock Detector

This block decides whether a divided feedback clock runs at the same rate as a reference clock. Both clocks are brought into a faster system clock through two-flop synchronizers. Each rising edge advances its own counter. While the block is hunting, any drift of more than two counts between the counters restarts the measurement. A full session of reference pulses with the counts kept that close raises the lock status.

Once locked, the block keeps counting. Every fourth reference pulse it compares the two counts. At a fixed maximum reference count it clears both counters and stays locked. If a fourth-pulse comparison finds a drift above two, the block enters a failed state: lock drops, a trap flag is set and the enable that forwards the reference clock is removed. A software disconnect input forces the same failed state. Only the power-on reset leaves the failed state. The system reset clears the counters but not the failure. The trap flag alone can be cleared by a write-one pulse.

Top module: `pll_lock_watch`

## Requirements
- R1: Each rising edge of `ref_clk_i` and of `fb_clk_i` advances its own counter by one. An edge is seen through a two-flop synchronizer followed by an edge detector.
- R2: While hunting, an absolute count difference greater than 2 clears both counters, whichever clock is faster. This raises neither the trap nor gate loss.
- R3: While hunting, `lock_o` goes to 1 when the reference count reaches LOCK_COUNT with the difference at 2 or less. It is not set before that reference edge.
- R4: While locked, the difference is checked whenever the new reference count is a multiple of 4. A difference of 2 or less keeps the lock. A difference above 2 enters the failed state.
- R5: While locked with no failure, both counters are cleared when the reference count reaches MAX_COUNT, and `lock_o` stays 1.
- R6: Entering the failed state drives `lock_o` to 0 and `ref_gate_o` to 0, and sets `trap_o` to 1.
- R7: The failed state, including `lock_o`=0 and `ref_gate_o`=0, persists through any clock activity and through `rst_n`. Only `por_n` low clears it.
- R8: `disc_i` high forces the failed state from the hunting or locked state.
- R9: `rst_n` low, when not failed, returns the block to hunting with cleared counters, `lock_o`=0 and `ref_gate_o`=1. A full new session is then needed to lock.
- R10: A `trap_clr_i` pulse clears `trap_o` and has no effect on `lock_o` or `ref_gate_o`. If a failure occurs in the same cycle, the set wins.
- R11: After `por_n` low, the outputs are `lock_o`=0, `trap_o`=0 and `ref_gate_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times faster than either monitored clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | System reset, synchronous, active low; clears counters, not the failure |
| ref_clk_i | input | 1 | Reference clock, asynchronous |
| fb_clk_i | input | 1 | Divided feedback clock, asynchronous |
| disc_i | input | 1 | Software disconnect control; forces failure |
| trap_clr_i | input | 1 | Write-one-to-clear pulse for the trap flag |
| lock_o | output | 1 | Lock status |
| trap_o | output | 1 | Sticky loss-of-lock trap flag |
| ref_gate_o | output | 1 | Enable that forwards the reference clock |

## Verification
The bench sweeps the feedback phase across a whole reference period. In every sweep step lock must appear exactly at the sixteenth reference edge. A design that measured signed drift, or that checked the bound off by one, would lock late or never lock for some phases. A slower and a faster feedback clock must both keep the block hunting without a trap; a one-sided difference would let one of them lock or wrap. Stopping the feedback clock must leave two missing edges tolerated and must fail the block after more are missed. A design whose periodic restart dropped the lock, or whose failure could be undone by the system reset or by renewed clock activity, would show lock or gate enable returning.

// File: rtl/lockdet_pkg.sv
// Shared types for the clock-pair lock detector.
package lockdet_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_FAILED = 2'd2
    } lock_state_t;
endpackage

// File: rtl/lockdet_edge_sync.sv
// Synchronizes an asynchronous clock into the system domain and emits a
// one-cycle pulse per rising edge. Assumes the input stays high and low
// for at least two system clocks each.
module lockdet_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] pipe_q;

    // Shift chain: STAGES synchronizer flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], async_i};
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/lockdet_count_pair.sv
// Reference and feedback pulse counters. Offers the next-cycle counts and
// their absolute difference so the controller can decide on the new values.
// The feedback counter saturates; the reference counter is bounded by the
// controller's restart.
module lockdet_count_pair #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_ev,
    input  logic          fb_ev,
    input  logic          clear,
    output logic [CW-1:0] ref_nx,
    output logic [CW-1:0] diff_nx
);
    logic [CW-1:0] ref_q, fb_q, fb_nx;

    // Next values: increment on each event, saturate the feedback side.
    always_comb begin
        ref_nx = ref_q + {{(CW-1){1'b0}}, ref_ev};
        fb_nx  = (fb_ev && (fb_q != {CW{1'b1}})) ? fb_q + 1'b1 : fb_q;
        diff_nx = (ref_nx >= fb_nx) ? ref_nx - fb_nx : fb_nx - ref_nx;
    end

    // Counter registers: cleared on reset or controller request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ref_q <= '0;
            fb_q  <= '0;
        end else begin
            ref_q <= ref_nx;
            fb_q  <= fb_nx;
        end
    end

    // R2/R5: a clear leaves both counters at zero
    assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ref_q == '0 && fb_q == '0));
    // R1: the reference count never moves without an event
    assert_ref_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !ref_ev) |=> $stable(ref_q));
endmodule

// File: rtl/lockdet_ctrl.sv
// Lock controller: hunting, locked and failed states, the sticky trap and
// the reference gate. Power-on reset alone leaves the failed state.
module lockdet_ctrl
    import lockdet_pkg::*;
#(
    parameter int CW         = 8,
    parameter int LOCK_COUNT = 224,
    parameter int MAX_COUNT  = 232
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          ref_ev,
    input  logic [CW-1:0] ref_nx,
    input  logic [CW-1:0] diff_nx,
    input  logic          disc_i,
    input  logic          trap_clr_i,
    output logic          cnt_clear,
    output logic          lock_o,
    output logic          trap_o,
    output logic          gate_o
);
    localparam logic [CW-1:0] LOCK_V  = CW'(LOCK_COUNT);
    localparam logic [CW-1:0] MAX_V   = CW'(MAX_COUNT);
    localparam logic [CW-1:0] LIMIT_V = CW'(2);

    lock_state_t state_q, state_nx;
    logic fail_evt, drift, quarter;
    logic lock_q, trap_q, gate_q;

    // Decide next state and counter clearing from the next counts.
    always_comb begin
        drift     = diff_nx > LIMIT_V;
        quarter   = ref_ev && (ref_nx[1:0] == 2'b00);
        state_nx  = state_q;
        cnt_clear = 1'b0;
        fail_evt  = 1'b0;
        case (state_q)
            ST_HUNT: begin
                if (drift) cnt_clear = 1'b1;
                else if (ref_ev && ref_nx == LOCK_V) state_nx = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (quarter && drift) begin
                    state_nx = ST_FAILED;
                    fail_evt = 1'b1;
                end else if (ref_ev && ref_nx == MAX_V) begin
                    cnt_clear = 1'b1;
                end
            end
            default: cnt_clear = 1'b1;
        endcase
        if (disc_i && state_q != ST_FAILED) begin
            state_nx = ST_FAILED;
            fail_evt = 1'b1;
        end
        if (state_nx == ST_FAILED) cnt_clear = 1'b1;
    end

    // State, lock and gate registers with the two reset levels.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q <= ST_HUNT;
            lock_q  <= 1'b0;
            gate_q  <= 1'b1;
        end else if (!rst_n) begin
            state_q <= (state_q == ST_FAILED) ? ST_FAILED : ST_HUNT;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            lock_q  <= (state_nx == ST_LOCKED);
            gate_q  <= gate_q & (state_nx != ST_FAILED);
        end
    end

    // Sticky trap: set on a failure, cleared by a write-one pulse.
    always_ff @(posedge clk) begin
        if (!por_n)                 trap_q <= 1'b0;
        else if (fail_evt && rst_n) trap_q <= 1'b1;
        else if (trap_clr_i)        trap_q <= 1'b0;
    end

    assign lock_o = lock_q;
    assign trap_o = trap_q;
    assign gate_o = gate_q;

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_FAILED) |=> (state_q == ST_FAILED && !gate_o && !lock_o));
    assert_disc_fails_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        disc_i |=> (!gate_o && !lock_o));
    assert_trap_on_fail_R6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(gate_o) |-> trap_o);
    assert_lock_on_ref_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(lock_o) |-> $past(ref_ev));
endmodule

// File: rtl/pll_lock_watch.sv
// Top level of the clock-pair lock detector. Synchronizes both clocks,
// counts their edges and judges lock. Assumes clk runs at least four
// times faster than either monitored clock.
module pll_lock_watch #(
    parameter int LOCK_COUNT  = 224,
    parameter int MAX_COUNT   = 232,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic ref_clk_i,
    input  logic fb_clk_i,
    input  logic disc_i,
    input  logic trap_clr_i,
    output logic lock_o,
    output logic trap_o,
    output logic ref_gate_o
);
    localparam int CW = $clog2(MAX_COUNT + 8);

    logic          sys_rst_n;
    logic [1:0]    clk_in, clk_ev;
    logic          cnt_clear;
    logic [CW-1:0] ref_nx, diff_nx;

    assign sys_rst_n = por_n & rst_n;
    assign clk_in    = {fb_clk_i, ref_clk_i};

    // One synchronizer and edge detector per monitored clock.
    for (genvar g = 0; g < 2; g++) begin : g_sync
        lockdet_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (sys_rst_n),
            .async_i (clk_in[g]),
            .rise_o  (clk_ev[g])
        );
    end

    lockdet_count_pair #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .ref_ev  (clk_ev[0]),
        .fb_ev   (clk_ev[1]),
        .clear   (cnt_clear),
        .ref_nx  (ref_nx),
        .diff_nx (diff_nx)
    );

    lockdet_ctrl #(.CW(CW), .LOCK_COUNT(LOCK_COUNT), .MAX_COUNT(MAX_COUNT)) u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .ref_ev     (clk_ev[0]),
        .ref_nx     (ref_nx),
        .diff_nx    (diff_nx),
        .disc_i     (disc_i),
        .trap_clr_i (trap_clr_i),
        .cnt_clear  (cnt_clear),
        .lock_o     (lock_o),
        .trap_o     (trap_o),
        .gate_o     (ref_gate_o)
    );

    assert_gate_implies_trap_or_clear_R6: assert property (@(posedge clk) disable iff (!por_n)
        (!ref_gate_o) |-> !lock_o);
endmodule

// File: tb/pll_lock_watch_test.sv
// Bench: drives both clocks as waveforms counted in system ticks and checks
// lock, trap and gate against arithmetic expectations.
module pll_lock_watch_test;
    localparam int LC = 16;
    localparam int MC = 24;
    localparam int RP = 8;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b1;
    logic ref_clk = 1'b0, fb_clk = 1'b0;
    logic disc = 1'b0, tclr = 1'b0;
    logic lock, trap, gate;

    int n_chk = 0, n_bad = 0;
    int tk = 0;
    int fb_per = 8, fb_ph = 0;
    bit ref_en = 1'b0, fb_en = 1'b0;

    pll_lock_watch #(.LOCK_COUNT(LC), .MAX_COUNT(MC)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .ref_clk_i(ref_clk),
        .fb_clk_i(fb_clk), .disc_i(disc), .trap_clr_i(tclr),
        .lock_o(lock), .trap_o(trap), .ref_gate_o(gate)
    );

    always #2 clk = ~clk;

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_clk = ref_en && ((tk % RP) < RP / 2);
            fb_clk  = fb_en && (((tk + fb_ph) % fb_per) < fb_per / 2);
            tk++;
        end
    endtask

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if ({lock, trap, gate} !== exp) begin
            n_bad++;
            $display("FAIL %s: {lock,trap,gate} got %b expected %b", req, {lock, trap, gate}, exp);
        end
    endtask

    task automatic power_on(input int per, input int ph);
        ref_en = 0; fb_en = 0; por_n = 0;
        tick(3);
        por_n = 1;
        fb_per = per; fb_ph = ph; tk = 0;
        ref_en = 1; fb_en = 1;
    endtask

    initial begin
        // R11: reset values
        power_on(8, 0);
        check("R11", 3'b001);

        // R1/R3: lock exactly at the LC-th reference edge, swept over phase
        for (int ph = 0; ph < 8; ph++) begin
            power_on(8, ph);
            tick(RP * (LC - 1) - 1);
            check("R3 early", 3'b001);
            tick(9);
            check("R1 R3 lock", 3'b101);
        end

        // R5: several periodic restarts keep the lock
        tick(RP * 50);
        check("R5", 3'b101);
        // R10: clear pulse while locked changes nothing
        tclr = 1; tick(1); tclr = 0; tick(1);
        check("R10 no effect", 3'b101);

        // R4: two missing feedback edges are tolerated
        fb_en = 0;
        tick(14);
        check("R4 tolerance", 3'b101);
        // R4/R6: more missing edges fail the block
        tick(130);
        check("R4 R6 fail", 3'b010);

        // R7: clocks back, then system reset: still failed
        fb_en = 1;
        tick(RP * 40);
        check("R7 clocks", 3'b010);
        rst_n = 0; tick(3); rst_n = 1;
        tick(RP * 20);
        check("R7 rst_n", 3'b010);

        // R10: trap cleared, lock and gate stay failed
        tclr = 1; tick(1); tclr = 0; tick(1);
        check("R10 clear", 3'b000);
        tick(RP * 20);
        check("R10 held", 3'b000);

        // R11: power-on reset leaves the failed state
        power_on(8, 0);
        check("R11 after fail", 3'b001);

        // R2: slower and faster feedback never lock nor trap
        power_on(10, 0);
        tick(RP * 48);
        check("R2 slow fb", 3'b001);
        power_on(6, 0);
        tick(RP * 48);
        check("R2 fast fb", 3'b001);

        // R8: disconnect while locked
        power_on(8, 0);
        tick(RP * LC + 8);
        check("R8 pre", 3'b101);
        disc = 1; tick(1); disc = 0; tick(2);
        check("R8 locked", 3'b010);

        // R8: disconnect while hunting
        power_on(8, 0);
        tick(20);
        disc = 1; tick(1); disc = 0; tick(2);
        check("R8 hunting", 3'b010);

        // R9: system reset while locked returns to hunting
        power_on(8, 0);
        tick(RP * LC + 8);
        rst_n = 0; tick(2);
        check("R9 in reset", 3'b001);
        rst_n = 1;
        tick(RP * (LC - 2));
        check("R9 relock wait", 3'b001);
        tick(RP * 4);
        check("R9 relock", 3'b101);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule